// File: doc/BRIEF.md
# Two-Level Slot-Reserved Round-Robin Bus Arbiter

This block decides which of several initiators owns a shared on-chip bus in each transfer slot. Arbitration is two-level. The first level is a wheel of reservation slots held in a small table. Each table entry names one initiator and carries a valid bit. When the current slot is reserved and its owner is requesting, the owner gets the bus. This reservation is how guaranteed bandwidth is delivered to chosen initiators.

A slot is never left unused while someone is asking for the bus. If the slot has no valid owner, or if its owner is silent, the second level resolves the contention. That level is a round-robin picker among all requesters. It starts its search just after the most recent round-robin winner.

Every initiator uses the same interface: a request line in and a grant line out. The slot position advances once per clock, and each clock is one transfer slot. Software-side setup loads the table through a simple write port, and a write takes effect only while no initiator is requesting.

Top module: `tdma_rr_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every grant line is low and the slot index is 0.
- R2: The slot index rises by one on every clock edge and goes from DEPTH-1 back to 0. It does this whether or not any request is present.
- R3: The grant vector is registered and is at most one-hot. A request pattern sampled at a clock edge produces its grant after that edge.
- R4: When every request line is low at a clock edge, every grant line is low after that edge.
- R5: If the entry for the current slot is valid, its owner index (a binary initiator number) is below NUM_INIT, and that initiator is requesting, then that initiator is granted whatever the round-robin state is.
- R6: In all other cases with at least one request, the grant goes to the first requesting initiator found by searching upward, wrapping from NUM_INIT-1 to 0, starting one above the last round-robin winner.
- R7: Only a round-robin win moves the round-robin pointer. A reserved-slot grant leaves the pointer unchanged.
- R8: A table write (entry address, owner index, valid bit) is applied at a clock edge only when all request lines are low there. Otherwise it is dropped.
- R9: A grant line is high only if the same initiator's request was high at the edge that produced it.
- R10: After reset, every table entry is invalid, and the round-robin pointer is set so that initiator 0 has first claim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one transfer slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_INIT | Per-initiator bus request |
| gnt | output | NUM_INIT | Registered per-initiator grant, at most one-hot |
| slot_idx | output | $clog2(DEPTH) | Slot currently being arbitrated |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | $clog2(DEPTH) | Table entry to write |
| cfg_owner | input | $clog2(NUM_INIT) | Initiator index for the entry |
| cfg_valid | input | 1 | Valid bit for the entry |

## Verification
Some properties are checked on every cycle by assertions: the grant is at most one-hot, a grant appears only for a sampled request, no requests leave the bus idle, the slot index steps and wraps, a requesting slot owner wins, and reserved wins leave the round-robin pointer in place. Other behaviours can only be shown by the bench's scenarios. These are the exact round-robin order across a mix of reserved and free slots, the ordering left after reserved wins interrupt a run, the effect of a table write that was dropped because a request was present, and the treatment of entries whose valid bit is clear.

// File: rtl/tdma_arb_pkg.sv
package tdma_arb_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_SLOT = 2'd1,
      SRC_RR   = 2'd2
   } grant_src_e;
endpackage

// File: rtl/arb_slot_table.sv
module arb_slot_table #(
   parameter int DEPTH    = 8,
   parameter int NUM_INIT = 4,
   localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int IW = (NUM_INIT > 1) ? $clog2(NUM_INIT) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_addr,
   input  logic [IW-1:0] wr_owner,
   input  logic          wr_valid,
   output logic [SW-1:0] slot_q,
   output logic [IW-1:0] cur_owner,
   output logic          cur_valid
);
   localparam logic [SW-1:0] LAST = SW'(DEPTH - 1);

   logic [IW-1:0] own_q [DEPTH];
   logic          val_q [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               own_q[e] <= '0;
               val_q[e] <= 1'b0;
            end else if (wr_en && wr_addr == SW'(e)) begin
               own_q[e] <= wr_owner;
               val_q[e] <= wr_valid;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              slot_q <= '0;
      else if (slot_q == LAST) slot_q <= '0;
      else                     slot_q <= slot_q + SW'(1);
   end

   assign cur_owner = own_q[slot_q];
   assign cur_valid = val_q[slot_q];

   assert_slot_step_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q != LAST) |=> (slot_q == $past(slot_q) + SW'(1)));
   assert_slot_wrap_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q == LAST) |=> (slot_q == '0));
endmodule

// File: rtl/arb_rr_picker.sv
module arb_rr_picker #(
   parameter int NUM_INIT = 4,
   localparam int IW = (NUM_INIT > 1) ? $clog2(NUM_INIT) : 1
) (
   input  logic [NUM_INIT-1:0] req,
   input  logic [IW-1:0]       last_win,
   output logic                found,
   output logic [IW-1:0]       winner
);
   always_comb begin
      found  = 1'b0;
      winner = last_win;
      for (int k = 1; k <= NUM_INIT; k++) begin
         int idx;
         idx = int'(last_win) + k;
         if (idx >= NUM_INIT) idx = idx - NUM_INIT;
         if (!found && req[idx]) begin
            found  = 1'b1;
            winner = IW'(idx);
         end
      end
   end
endmodule

// File: rtl/tdma_rr_arbiter.sv
module tdma_rr_arbiter
   import tdma_arb_pkg::*;
#(
   parameter int NUM_INIT = 4,
   parameter int DEPTH    = 8,
   localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int IW = (NUM_INIT > 1) ? $clog2(NUM_INIT) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_INIT-1:0] req,
   output logic [NUM_INIT-1:0] gnt,
   output logic [SW-1:0]       slot_idx,
   input  logic                cfg_we,
   input  logic [SW-1:0]       cfg_addr,
   input  logic [IW-1:0]       cfg_owner,
   input  logic                cfg_valid
);
   generate
      if (NUM_INIT < 2) begin : g_bad_init
         $error("NUM_INIT must be at least 2");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   logic [IW-1:0] cur_owner;
   logic          cur_valid;
   logic          idle;
   logic          owner_hit;
   logic          rr_found;
   logic [IW-1:0] rr_winner;
   logic [IW-1:0] rr_ptr_q;
   grant_src_e    src;
   logic [NUM_INIT-1:0] gnt_d;
   logic [NUM_INIT-1:0] gnt_q;

   assign idle = (req == '0);

   arb_slot_table #(.DEPTH(DEPTH), .NUM_INIT(NUM_INIT)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && idle),
      .wr_addr  (cfg_addr),
      .wr_owner (cfg_owner),
      .wr_valid (cfg_valid),
      .slot_q   (slot_idx),
      .cur_owner(cur_owner),
      .cur_valid(cur_valid)
   );

   arb_rr_picker #(.NUM_INIT(NUM_INIT)) u_rr (
      .req     (req),
      .last_win(rr_ptr_q),
      .found   (rr_found),
      .winner  (rr_winner)
   );

   assign owner_hit = cur_valid && (int'(cur_owner) < NUM_INIT) && req[cur_owner];

   always_comb begin
      gnt_d = '0;
      src   = SRC_NONE;
      if (owner_hit) begin
         src              = SRC_SLOT;
         gnt_d[cur_owner] = 1'b1;
      end else if (rr_found) begin
         src              = SRC_RR;
         gnt_d[rr_winner] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_q    <= '0;
         rr_ptr_q <= IW'(NUM_INIT - 1);
      end else begin
         gnt_q <= gnt_d;
         if (src == SRC_RR) rr_ptr_q <= rr_winner;
      end
   end

   assign gnt = gnt_q;

   assert_onehot_grant_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   assert_idle_no_grant_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> (gnt == '0));
   assert_owner_wins_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      owner_hit |=> (gnt[$past(cur_owner)] && $onehot(gnt)));
   assert_ptr_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (src != SRC_RR) |=> $stable(rr_ptr_q));

   generate
      for (genvar i = 0; i < NUM_INIT; i++) begin : g_chk
         assert_grant_needs_req_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            gnt[i] |-> $past(req[i]));
      end
   endgenerate
endmodule

// File: tb/tdma_rr_arbiter_test.sv
module tdma_rr_arbiter_test;
   localparam int N = 4;
   localparam int D = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req = '0;
   logic [3:0] gnt;
   logic [2:0] slot_idx;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [1:0] cfg_owner = '0;
   logic       cfg_valid = 1'b0;

   always #10 clk = ~clk;

   tdma_rr_arbiter #(.NUM_INIT(N), .DEPTH(D)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .slot_idx(slot_idx),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_owner(cfg_owner), .cfg_valid(cfg_valid)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int         m_slot;
   int         m_ptr;
   logic [1:0] t_own [D];
   logic       t_val [D];
   logic [3:0] exp_gnt;
   string      exp_tag;

   localparam logic [3:0] VEC [24] = '{
      4'b1111, 4'b0110, 4'b1001, 4'b0001, 4'b0101, 4'b1111, 4'b0010, 4'b1000,
      4'b1100, 4'b0011, 4'b1110, 4'b0100, 4'b1111, 4'b1010, 4'b0111, 4'b0000,
      4'b1101, 4'b0001, 4'b1011, 4'b1111, 4'b0110, 4'b1001, 4'b1111, 4'b0101
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   task automatic step(input logic [3:0] r, input logic we, input logic [2:0] a,
                       input logic [1:0] o, input logic v, input string tag_over);
      logic [3:0] pr;
      int w;
      check(exp_tag, 32'(gnt), 32'(exp_gnt));
      check("R3 one-hot", 32'($countones(gnt) <= 1), 32'd1);
      check("R2 slot", 32'(slot_idx), 32'(m_slot));
      req = r; cfg_we = we; cfg_addr = a; cfg_owner = o; cfg_valid = v;
      pr = r;
      exp_gnt = '0;
      if (pr == 0) exp_tag = "R4";
      else if (t_val[m_slot] && pr[t_own[m_slot]]) begin
         exp_gnt = 4'b1 << t_own[m_slot];
         exp_tag = "R5";
      end else begin
         w = -1;
         for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (m_ptr + k) % N;
            if (w < 0 && pr[idx]) w = idx;
         end
         exp_gnt = 4'b1 << w;
         m_ptr = w;
         exp_tag = "R6/R7";
      end
      if (tag_over != "") exp_tag = tag_over;
      if (we && pr == 0) begin
         t_own[a] = o;
         t_val[a] = v;
      end
      m_slot = (m_slot + 1) % D;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < D; i++) begin t_own[i] = '0; t_val[i] = 1'b0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 gnt in reset", 32'(gnt), 32'd0);
      check("R1 slot in reset", 32'(slot_idx), 32'd0);
      rst_n = 1'b1;
      m_slot = 0; m_ptr = N - 1; exp_gnt = '0; exp_tag = "R1";

      // R10: empty table and pointer giving initiator 0 first claim
      step(4'b1111, 0, 0, 0, 0, "R10");
      step(4'b1110, 0, 0, 0, 0, "R10 next");
      // idle run over a full wheel: counter keeps moving, no grants (R2, R4)
      for (int i = 0; i < D + 3; i++) step(4'b0000, 0, 0, 0, 0, "");

      // load table while idle (R8)
      step(4'b0000, 1, 3'd1, 2'd2, 1, "R8 load");
      step(4'b0000, 1, 3'd3, 2'd0, 1, "R8 load");
      step(4'b0000, 1, 3'd4, 2'd3, 1, "R8 load");
      step(4'b0000, 1, 3'd6, 2'd1, 0, "R8 load");
      // write attempt with a request present must be dropped (R8)
      step(4'b0001, 1, 3'd4, 2'd1, 1, "");
      step(4'b0000, 0, 0, 0, 0, "");
      // reach slot 4 and request 1 and 3: entry must still name 3
      while (m_slot != 4) step(4'b0000, 0, 0, 0, 0, "");
      step(4'b1010, 0, 0, 0, 0, "R8 dropped write");
      step(4'b0000, 0, 0, 0, 0, "R8 dropped write");
      // slot 6 entry invalid: owner 1 gets no priority (R5 valid bit, R6)
      while (m_slot != 6) step(4'b0000, 0, 0, 0, 0, "");
      step(4'b0010, 0, 0, 0, 0, "");

      // vector table walk
      foreach (VEC[i]) step(VEC[i], 0, 0, 0, 0, "");
      step(4'b0000, 0, 0, 0, 0, "");
      step(4'b0000, 0, 0, 0, 0, "");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule